// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block gathers interrupt events from a timer overflow, an external pin, an eight-bit input port and up to fourteen peripheral sources. Each source has a sticky flag and an enable bit. The block drives one request line to a CPU. Hardware only ever sets a flag. Software clears it by writing the flag register through a small register port. The CPU side, meaning vectoring and context save, is outside this block. Peripherals are represented by single-cycle event pulses.

Masking works on two levels. A global enable gates the whole request. A group enable gates only the peripheral sources; the timer, pin and port sources do not depend on it. The external pin has a selectable trigger edge. The port source compares each port bit against a snapshot of the port. The snapshot is reloaded whenever software reads the port address. A changed bit raises the flag only when its own change-enable bit is set.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, every register at addresses 0, 1, 2, 4 and 5 reads 0 and `irq_o` is low.
- R2: A source event sets that source's flag at the next clock edge whether or not the source is enabled. Flag bits at address 1 are: bit 0 timer, bit 1 external pin, bit 2 port change. Peripheral flag i is bit i of address 5.
- R3: A flag whose enable bit is 0 never raises `irq_o`. Control register (address 0) bits: 0 global, 1 peripheral group, 2 timer, 3 pin, 4 port, 5 pin rising-edge select. Peripheral enable i is bit i of address 4.
- R4: With the global enable at 0, `irq_o` is low. With it at 1, `irq_o` is high whenever some enabled source has its flag set, subject to R5.
- R5: The peripheral group enable masks the peripheral sources only. The timer, pin and port sources request regardless of it.
- R6: Flags are never cleared by hardware. A write to a flag address loads the written bits. A flag left set raises `irq_o` again once the enables are restored.
- R7: If a hardware event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R8: The port-change flag sets when any port bit with its change-enable (address 2, bit i for port bit i) set differs from the snapshot, on a rising or a falling change. Bits whose change-enable is 0 are ignored.
- R9: A read of address 3 returns the live port value and reloads the snapshot from it. Until that read, a persisting difference keeps setting the port-change flag, even after software clears the flag.
- R10: With the edge select at 1 the pin flag sets on a 0-to-1 transition; with the edge select at 0 it sets on a 1-to-0 transition; the opposite transition does nothing.
- R11: `irq_o` stays low in the cycle of an enabled event and is high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_ovf_i | input | 1 | Timer overflow event pulse |
| ext_pin_i | input | 1 | External interrupt pin (synchronous) |
| port_i | input | 8 | Port inputs watched for changes |
| periph_evt_i | input | NUM_PERIPH | Peripheral event pulses |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rd_i | input | 1 | Register read strobe (matters at address 3) |
| reg_rdata_o | output | 16 | Register read data, combinational |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Timer and peripheral pulses are applied under each combination of global, group and source enable. This separates source masking from group masking and shows that the core sources bypass the group enable. Port stimulus toggles an enabled bit and a disabled bit, both rising and falling, with and without a snapshot read in between. This distinguishes a comparison against the snapshot from a one-cycle edge detector. Pin transitions in both directions under both edge selects show which edge triggers. A flag clear issued in the same cycle as an event shows which side has priority. A behavioural model compares the request line on every cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int PORT_W  = 8;
  localparam int CTRL_W  = 6;
  localparam int CORE_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFLAG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PCHGEN = 3'd2;
  localparam logic [ADDR_W-1:0] A_PORT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_PEN    = 3'd4;
  localparam logic [ADDR_W-1:0] A_PFLAG  = 3'd5;

  localparam int C_GLOB = 0;
  localparam int C_GRP  = 1;
  localparam int C_TMR  = 2;
  localparam int C_EXT  = 3;
  localparam int C_PORT = 4;
  localparam int C_RISE = 5;

  localparam int F_TMR  = 0;
  localparam int F_EXT  = 1;
  localparam int F_PORT = 2;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (set_i[i])  flag_q <= 1'b1;  // hardware set beats software write
      else if (wr_i)      flag_q <= wdata_i[i];
    end
    assign q_o[i] = flag_q;
  end
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  always_comb begin
    if (rise_sel_i) evt_o = pin_i & ~prev_q;
    else            evt_o = ~pin_i & prev_q;
  end
endmodule

// File: rtl/irq_port_chg.sv
module irq_port_chg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] port_i,
  input  logic [W-1:0] en_i,
  input  logic         refresh_i,
  output logic         evt_o
);
  logic [W-1:0] snap_q;
  logic [W-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (refresh_i) snap_q <= port_i;
  end

  assign diff  = (port_i ^ snap_q) & en_i;
  assign evt_o = |diff;
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int CW = 3,
  parameter int PW = 14
) (
  input  logic          glob_en_i,
  input  logic          grp_en_i,
  input  logic [CW-1:0] core_flag_i,
  input  logic [CW-1:0] core_en_i,
  input  logic [PW-1:0] per_flag_i,
  input  logic [PW-1:0] per_en_i,
  output logic          irq_o
);
  logic core_hit;
  logic per_hit;

  assign core_hit = |(core_flag_i & core_en_i);
  assign per_hit  = grp_en_i & (|(per_flag_i & per_en_i));
  assign irq_o    = glob_en_i & (core_hit | per_hit);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_PERIPH = 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tmr_ovf_i,
  input  logic                  ext_pin_i,
  input  logic [PORT_W-1:0]     port_i,
  input  logic [NUM_PERIPH-1:0] periph_evt_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic                  reg_wr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  input  logic                  reg_rd_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  irq_o
);
  logic [CTRL_W-1:0]     ctrl_q;
  logic [PORT_W-1:0]     pchg_en_q;
  logic [NUM_PERIPH-1:0] periph_en_q;
  logic [CORE_W-1:0]     core_flag_q;
  logic [NUM_PERIPH-1:0] periph_flag_q;
  logic [CORE_W-1:0]     core_set;
  logic [CORE_W-1:0]     core_en;
  logic                  ext_evt;
  logic                  port_evt;
  logic                  wr_ctrl, wr_cflag, wr_pchg, wr_pen, wr_pflag;
  logic                  rd_port;
  logic                  unused_wdata;

  assign wr_ctrl  = reg_wr_i && (reg_addr_i == A_CTRL);
  assign wr_cflag = reg_wr_i && (reg_addr_i == A_CFLAG);
  assign wr_pchg  = reg_wr_i && (reg_addr_i == A_PCHGEN);
  assign wr_pen   = reg_wr_i && (reg_addr_i == A_PEN);
  assign wr_pflag = reg_wr_i && (reg_addr_i == A_PFLAG);
  assign rd_port  = reg_rd_i && (reg_addr_i == A_PORT);
  assign unused_wdata = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      pchg_en_q   <= '0;
      periph_en_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q      <= reg_wdata_i[CTRL_W-1:0];
      if (wr_pchg) pchg_en_q   <= reg_wdata_i[PORT_W-1:0];
      if (wr_pen)  periph_en_q <= reg_wdata_i[NUM_PERIPH-1:0];
    end
  end

  irq_edge_det u_ext (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_pin_i),
    .rise_sel_i (ctrl_q[C_RISE]),
    .evt_o      (ext_evt)
  );

  irq_port_chg #(.W(PORT_W)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .port_i    (port_i),
    .en_i      (pchg_en_q),
    .refresh_i (rd_port),
    .evt_o     (port_evt)
  );

  always_comb begin
    core_set         = '0;
    core_set[F_TMR]  = tmr_ovf_i;
    core_set[F_EXT]  = ext_evt;
    core_set[F_PORT] = port_evt;
    core_en          = '0;
    core_en[F_TMR]   = ctrl_q[C_TMR];
    core_en[F_EXT]   = ctrl_q[C_EXT];
    core_en[F_PORT]  = ctrl_q[C_PORT];
  end

  irq_flag_bank #(.W(CORE_W)) u_core_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (core_set),
    .wr_i    (wr_cflag),
    .wdata_i (reg_wdata_i[CORE_W-1:0]),
    .q_o     (core_flag_q)
  );

  irq_flag_bank #(.W(NUM_PERIPH)) u_per_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (periph_evt_i),
    .wr_i    (wr_pflag),
    .wdata_i (reg_wdata_i[NUM_PERIPH-1:0]),
    .q_o     (periph_flag_q)
  );

  irq_combine #(.CW(CORE_W), .PW(NUM_PERIPH)) u_comb (
    .glob_en_i   (ctrl_q[C_GLOB]),
    .grp_en_i    (ctrl_q[C_GRP]),
    .core_flag_i (core_flag_q),
    .core_en_i   (core_en),
    .per_flag_i  (periph_flag_q),
    .per_en_i    (periph_en_q),
    .irq_o       (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL:   reg_rdata_o[CTRL_W-1:0]     = ctrl_q;
      A_CFLAG:  reg_rdata_o[CORE_W-1:0]     = core_flag_q;
      A_PCHGEN: reg_rdata_o[PORT_W-1:0]     = pchg_en_q;
      A_PORT:   reg_rdata_o[PORT_W-1:0]     = port_i;
      A_PEN:    reg_rdata_o[NUM_PERIPH-1:0] = periph_en_q;
      A_PFLAG:  reg_rdata_o[NUM_PERIPH-1:0] = periph_flag_q;
      default:  reg_rdata_o                 = '0;
    endcase
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_PERIPH = 14
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tmr_ovf_i,
  input logic                  reg_wr_i,
  input logic [ADDR_W-1:0]     reg_addr_i,
  input logic                  irq_o,
  input logic [CTRL_W-1:0]     ctrl_q,
  input logic [CORE_W-1:0]     core_flag_q,
  input logic [NUM_PERIPH-1:0] periph_flag_q,
  input logic [NUM_PERIPH-1:0] periph_en_q
);
  AST_GLOBAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[C_GLOB] |-> !irq_o); // R4

  AST_NO_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[C_TMR] == 1'b0 && ctrl_q[C_EXT] == 1'b0 && ctrl_q[C_PORT] == 1'b0 &&
     periph_en_q == '0) |-> !irq_o); // R3

  AST_GROUP_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[C_GRP] && !(core_flag_q[F_TMR] && ctrl_q[C_TMR]) &&
     !(core_flag_q[F_EXT] && ctrl_q[C_EXT]) &&
     !(core_flag_q[F_PORT] && ctrl_q[C_PORT])) |-> !irq_o); // R5

  AST_CORE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == A_CFLAG) |=>
      ((core_flag_q & $past(core_flag_q)) == $past(core_flag_q))); // R6

  AST_PER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == A_PFLAG) |=>
      ((periph_flag_q & $past(periph_flag_q)) == $past(periph_flag_q))); // R6

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> core_flag_q[F_TMR]); // R7

  AST_TMR_IRQ_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_ovf_i && ctrl_q[C_TMR] && ctrl_q[C_GLOB] &&
     !(reg_wr_i && reg_addr_i == A_CTRL)) |=> irq_o); // R11
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tmr_ovf_i     (tmr_ovf_i),
  .reg_wr_i      (reg_wr_i),
  .reg_addr_i    (reg_addr_i),
  .irq_o         (irq_o),
  .ctrl_q        (ctrl_q),
  .core_flag_q   (core_flag_q),
  .periph_flag_q (periph_flag_q),
  .periph_en_q   (periph_en_q)
);

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
  localparam int NP = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          tmr_ovf_i = 1'b0;
  logic          ext_pin_i = 1'b0;
  logic [7:0]    port_i = '0;
  logic [NP-1:0] periph_evt_i = '0;
  logic [2:0]    reg_addr_i = '0;
  logic          reg_wr_i = 1'b0;
  logic [15:0]   reg_wdata_i = '0;
  logic          reg_rd_i = 1'b0;
  logic [15:0]   reg_rdata_o;
  logic          irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  irq_flag_ctrl #(.NUM_PERIPH(NP)) dut (
    .clk_i, .rst_ni, .tmr_ovf_i, .ext_pin_i, .port_i, .periph_evt_i,
    .reg_addr_i, .reg_wr_i, .reg_wdata_i, .reg_rd_i, .reg_rdata_o, .irq_o
  );

  // behavioural reference model
  logic [5:0]    m_ctrl;
  logic [2:0]    m_cf;
  logic [7:0]    m_pce, m_snap;
  logic [NP-1:0] m_pen, m_pf;
  logic          m_prev;
  logic          m_ext_ev, m_port_ev;

  function automatic logic model_irq();
    logic any_core, any_per;
    any_core = (m_cf[0] & m_ctrl[2]) | (m_cf[1] & m_ctrl[3]) | (m_cf[2] & m_ctrl[4]);
    any_per  = (m_pf & m_pen) != '0;
    return m_ctrl[0] & (any_core | (m_ctrl[1] & any_per));
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = '0; m_cf = '0; m_pce = '0; m_snap = '0;
      m_pen = '0; m_pf = '0; m_prev = 1'b0;
    end else begin
      m_ext_ev  = m_ctrl[5] ? (ext_pin_i && !m_prev) : (!ext_pin_i && m_prev);
      m_port_ev = ((port_i ^ m_snap) & m_pce) != 8'h00;
      if (reg_wr_i) begin
        case (reg_addr_i)
          3'd0: m_ctrl = reg_wdata_i[5:0];
          3'd1: m_cf   = reg_wdata_i[2:0];
          3'd2: m_pce  = reg_wdata_i[7:0];
          3'd4: m_pen  = reg_wdata_i[NP-1:0];
          3'd5: m_pf   = reg_wdata_i[NP-1:0];
          default: ;
        endcase
      end
      if (tmr_ovf_i) m_cf[0] = 1'b1;
      if (m_ext_ev)  m_cf[1] = 1'b1;
      if (m_port_ev) m_cf[2] = 1'b1;
      m_pf = m_pf | periph_evt_i;
      if (reg_rd_i && reg_addr_i == 3'd3) m_snap = port_i;
      m_prev = ext_pin_i;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      #2;
      check(irq_o === model_irq(), "R4 per-cycle irq vs model", irq_o, model_irq());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    logic [15:0] d;
    @(negedge clk_i);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #5 d = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
    check(d === exp, req, d, exp);
  endtask

  task automatic irq_chk(input logic exp, input string req);
    #3 check(irq_o === exp, req, irq_o, exp);
  endtask

  task automatic pulse_tmr();
    @(negedge clk_i); tmr_ovf_i = 1'b1;
    @(negedge clk_i); tmr_ovf_i = 1'b0;
  endtask

  task automatic pulse_per(input int b);
    @(negedge clk_i); periph_evt_i = '0; periph_evt_i[b] = 1'b1;
    @(negedge clk_i); periph_evt_i = '0;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    tick(3);
    rst_ni = 1'b1;

    // R1 reset state
    rd_chk(3'd0, 16'h0, "R1 ctrl reset");
    rd_chk(3'd1, 16'h0, "R1 core flags reset");
    rd_chk(3'd2, 16'h0, "R1 port change enables reset");
    rd_chk(3'd4, 16'h0, "R1 peripheral enables reset");
    rd_chk(3'd5, 16'h0, "R1 peripheral flags reset");
    irq_chk(1'b0, "R1 irq low after reset");

    // R2/R3 flags set while disabled, no request
    pulse_tmr();
    rd_chk(3'd1, 16'h1, "R2 timer flag set while disabled");
    irq_chk(1'b0, "R3 disabled timer flag gives no irq");
    pulse_per(5);
    rd_chk(3'd5, 16'h0020, "R2 peripheral flag set while disabled");

    // R4 global enable
    wr(3'd0, 16'h0005);
    irq_chk(1'b1, "R4 global+timer enable raises irq");
    wr(3'd0, 16'h0004);
    irq_chk(1'b0, "R4 global off blocks irq");

    // R5 group mask
    wr(3'd4, 16'h0020);
    wr(3'd0, 16'h0001);
    irq_chk(1'b0, "R5 group off masks peripheral");
    wr(3'd0, 16'h0003);
    irq_chk(1'b1, "R5 group on passes peripheral");
    wr(3'd0, 16'h0005);
    irq_chk(1'b1, "R5 timer bypasses group enable");

    // R6 sticky and re-assert
    wr(3'd0, 16'h0004);
    tick(5);
    rd_chk(3'd1, 16'h1, "R6 flag not cleared by hardware");
    wr(3'd0, 16'h0005);
    irq_chk(1'b1, "R6 request re-asserts on re-enable");
    wr(3'd1, 16'h0);
    rd_chk(3'd1, 16'h0, "R6 write 0 clears flag");
    irq_chk(1'b0, "R6 irq drops after clear");
    wr(3'd5, 16'h0);

    // R7 set wins over clear
    @(negedge clk_i);
    reg_addr_i = 3'd1; reg_wdata_i = 16'h0; reg_wr_i = 1'b1; tmr_ovf_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0; tmr_ovf_i = 1'b0;
    rd_chk(3'd1, 16'h1, "R7 hardware set wins over write 0");
    wr(3'd1, 16'h0);

    // R11 latency
    @(negedge clk_i); tmr_ovf_i = 1'b1;
    #2 check(irq_o === 1'b0, "R11 irq low in event cycle", irq_o, 1'b0);
    @(posedge clk_i); #1 check(irq_o === 1'b1, "R11 irq high next cycle", irq_o, 1'b1);
    @(negedge clk_i); tmr_ovf_i = 1'b0;
    wr(3'd1, 16'h0);

    // R8/R9 port change
    wr(3'd0, 16'h0011);
    wr(3'd2, 16'h0004);
    @(negedge clk_i); port_i = 8'h08;
    tick(1);
    rd_chk(3'd1, 16'h0, "R8 disabled port bit ignored");
    irq_chk(1'b0, "R8 no irq from disabled bit");
    @(negedge clk_i); port_i = 8'h0C;
    tick(1);
    rd_chk(3'd1, 16'h4, "R8 rising change on enabled bit");
    irq_chk(1'b1, "R8 port change raises irq");
    wr(3'd1, 16'h0);
    rd_chk(3'd1, 16'h4, "R9 mismatch re-sets flag before port read");
    rd_chk(3'd3, 16'h000C, "R9 port read returns live value");
    wr(3'd1, 16'h0);
    rd_chk(3'd1, 16'h0, "R9 flag stays clear after snapshot refresh");
    @(negedge clk_i); port_i = 8'h08;
    tick(1);
    rd_chk(3'd1, 16'h4, "R8 falling change on enabled bit");
    rd_chk(3'd3, 16'h0008, "R9 port read after falling change");
    wr(3'd1, 16'h0);

    // R10 edge select
    wr(3'd0, 16'h0029);
    @(negedge clk_i); ext_pin_i = 1'b1;
    tick(1);
    rd_chk(3'd1, 16'h2, "R10 rising edge with select 1");
    wr(3'd1, 16'h0);
    @(negedge clk_i); ext_pin_i = 1'b0;
    tick(1);
    rd_chk(3'd1, 16'h0, "R10 falling edge ignored with select 1");
    wr(3'd0, 16'h0009);
    @(negedge clk_i); ext_pin_i = 1'b1;
    tick(1);
    rd_chk(3'd1, 16'h0, "R10 rising edge ignored with select 0");
    @(negedge clk_i); ext_pin_i = 1'b0;
    tick(1);
    rd_chk(3'd1, 16'h2, "R10 falling edge with select 0");
    irq_chk(1'b1, "R10 pin flag raises irq");
    wr(3'd1, 16'h0);

    // R3 per-source peripheral enable
    wr(3'd0, 16'h0003);
    pulse_per(7);
    rd_chk(3'd5, 16'h0080, "R3 unenabled peripheral flag set");
    irq_chk(1'b0, "R3 unenabled peripheral gives no irq");
    pulse_per(5);
    irq_chk(1'b1, "R3 enabled peripheral raises irq");

    tick(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule